// File: doc/BRIEF.md
# Banked RTC register and extended RAM window

This block is the host-facing register file of a real-time clock. A 7-bit byte address from the host bus is decoded into four kinds of target: the ten time and alarm registers, the four control registers, 114 bytes of general-purpose RAM, and a small set of window registers. The window registers reach a 2048-byte extended RAM indirectly. One bit of control register A picks between two banks. Bank 0 shows the full general RAM. Bank 1 keeps the low part of the map and replaces the upper part with the extended RAM window.

The clock core that advances the time registers is not part of this block. It connects through a side port that reads and writes the time registers by index, and it raises an update-busy flag while it rolls the count. During that flag, host writes to the time registers are dropped. Control registers, general RAM and the extended RAM all stay fully usable.

Reads have one cycle of latency. The read data holds its value until the next read.

Top module: `rtc_bank_regs`

## Requirements
- R1: After synchronous reset, the time registers, the four control registers and both extended address registers are 00h. The bank is 0 and `bus_rdata` is 00h.
- R2: A read strobed on `bus_rd` at one clock edge presents its byte on `bus_rdata` after that edge. `bus_rdata` keeps its value at every edge without `bus_rd`.
- R3: Bit 4 of control register A (address 0Ah) selects the bank. 0 selects bank 0 and 1 selects bank 1, and `bank_sel` shows the bit.
- R4: Control registers A, B, C and D sit at 0Ah, 0Bh, 0Ch and 0Dh in both banks. All eight bits of each are readable and writable whether or not `upd_busy` is high, and they appear on `ctrl_a` through `ctrl_d`.
- R5: Time registers 0 to 9 sit at 00h–09h in both banks. While `upd_busy` is high, host writes to them are ignored. `core_rdata` shows the time register selected by `core_idx` without a clock delay, and shows 00h for an index of 10 or more.
- R6: In bank 0, addresses 0Eh–7Fh are 114 plain storage bytes. They read back what was last written, including while `upd_busy` is high.
- R7: In bank 1, addresses 0Eh–3Fh reach the same general RAM bytes as in bank 0.
- R8: In bank 1, 40h holds extended address bits 7:0 and 41h holds bits 10:8 in its bits 2:0. Bits 7:3 of 41h read as 0.
- R9: In bank 1, a read or write at 42h accesses the extended RAM byte at the 11-bit address formed from 41h and 40h.
- R10: In bank 1, addresses 43h–7Fh read 00h, and writes to them change no storage.
- R11: A core write with `core_wr` high to time index 0–9 always succeeds. When it meets a host write to the same register in the same cycle, the core value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Host byte address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, registered |
| upd_busy | input | 1 | Clock core is updating the time registers |
| core_wr | input | 1 | Clock core write strobe |
| core_idx | input | 4 | Time register index used by the clock core |
| core_wdata | input | 8 | Clock core write data |
| core_rdata | output | 8 | Time register selected by `core_idx` |
| ctrl_a | output | 8 | Control register A |
| ctrl_b | output | 8 | Control register B |
| ctrl_c | output | 8 | Control register C |
| ctrl_d | output | 8 | Control register D |
| bank_sel | output | 1 | Currently selected bank |

## Verification
The hardest state to reach is the full extended RAM. Every byte sits behind two address registers and a bank switch, so an error in how the high address bits are combined only shows up once distinct contents have been written across all eight high-address pages. The bench switches to bank 1 and sweeps all 2048 addresses with a pattern that depends on both address bytes. It then reloads the address registers and reads every byte back.

Aliasing between the banks is exposed by two steps. The general RAM is filled in bank 0 and partly rewritten in bank 1. The bank-1 dead zone is then written, and the bench returns to bank 0 to confirm the upper RAM bytes survived.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int N_TIME    = 10;
    localparam int N_CTRL    = 4;
    localparam int BANK_BIT  = 4;

    localparam logic [ADDR_W-1:0] CTRL_BASE  = 7'h0A;
    localparam logic [ADDR_W-1:0] GRAM_BASE  = 7'h0E;
    localparam logic [ADDR_W-1:0] B1_GRAM_HI = 7'h3F;
    localparam logic [ADDR_W-1:0] WIN_LO     = 7'h40;
    localparam logic [ADDR_W-1:0] WIN_HI     = 7'h41;
    localparam logic [ADDR_W-1:0] WIN_DAT    = 7'h42;

    localparam int N_GRAM = (1 << ADDR_W) - int'(GRAM_BASE);

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        RG_TIME,
        RG_CTRL,
        RG_GRAM,
        RG_XLO,
        RG_XHI,
        RG_XDAT,
        RG_NONE
    } region_e;

    typedef struct packed {
        region_e region;
        addr_t   idx;
    } decode_t;

    typedef struct packed {
        logic time_we;
        logic ctrl_we;
        logic gram_we;
        logic xlo_we;
        logic xhi_we;
        logic xdat_we;
    } wstrobe_t;

    function automatic decode_t map_addr(input addr_t a, input logic bank);
        decode_t d;
        d.idx    = '0;
        d.region = RG_NONE;
        if (a < CTRL_BASE) begin
            d.region = RG_TIME;
            d.idx    = a;
        end else if (a < GRAM_BASE) begin
            d.region = RG_CTRL;
            d.idx    = a - CTRL_BASE;
        end else if (!bank || a <= B1_GRAM_HI) begin
            d.region = RG_GRAM;
            d.idx    = a - GRAM_BASE;
        end else if (a == WIN_LO) begin
            d.region = RG_XLO;
        end else if (a == WIN_HI) begin
            d.region = RG_XHI;
        end else if (a == WIN_DAT) begin
            d.region = RG_XDAT;
        end
        return d;
    endfunction

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
    import rtc_bank_pkg::*;
(
    input  addr_t    addr,
    input  logic     bank,
    input  logic     wr,
    input  logic     rd,
    output decode_t  dec,
    output wstrobe_t wstb,
    output logic     xdat_re
);

    always_comb begin
        dec          = map_addr(addr, bank);
        wstb         = '0;
        wstb.time_we = wr && (dec.region == RG_TIME);
        wstb.ctrl_we = wr && (dec.region == RG_CTRL);
        wstb.gram_we = wr && (dec.region == RG_GRAM);
        wstb.xlo_we  = wr && (dec.region == RG_XLO);
        wstb.xhi_we  = wr && (dec.region == RG_XHI);
        wstb.xdat_we = wr && (dec.region == RG_XDAT);
        xdat_re      = rd && (dec.region == RG_XDAT);
    end

endmodule

// File: rtl/rtc_core_regs.sv
module rtc_core_regs
    import rtc_bank_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_time_we,
    input  logic                    host_ctrl_we,
    input  logic [3:0]              host_idx,
    input  byte_t                   host_wdata,
    input  logic                    upd_busy,
    input  logic                    core_wr,
    input  logic [3:0]              core_idx,
    input  byte_t                   core_wdata,
    output byte_t                   host_time_rd,
    output byte_t                   host_ctrl_rd,
    output logic [N_CTRL-1:0][7:0]  ctrl_q,
    output byte_t                   core_rdata
);

    byte_t time_q [N_TIME];

    for (genvar i = 0; i < N_TIME; i++) begin : g_time
        always_ff @(posedge clk) begin
            if (rst) begin
                time_q[i] <= '0;
            end else if (core_wr && core_idx == 4'(i)) begin
                time_q[i] <= core_wdata;
            end else if (host_time_we && !upd_busy && host_idx == 4'(i)) begin
                time_q[i] <= host_wdata;
            end
        end
    end

    for (genvar j = 0; j < N_CTRL; j++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[j] <= '0;
            end else if (host_ctrl_we && host_idx == 4'(j)) begin
                ctrl_q[j] <= host_wdata;
            end
        end
    end

    always_comb begin
        host_time_rd = '0;
        host_ctrl_rd = '0;
        core_rdata   = '0;
        for (int k = 0; k < N_TIME; k++) begin
            if (host_idx == 4'(k)) host_time_rd = time_q[k];
            if (core_idx == 4'(k)) core_rdata   = time_q[k];
        end
        for (int k = 0; k < N_CTRL; k++) begin
            if (host_idx == 4'(k)) host_ctrl_rd = ctrl_q[k];
        end
    end

endmodule

// File: rtl/rtc_gen_ram.sv
module rtc_gen_ram
    import rtc_bank_pkg::*;
#(
    parameter int DEPTH = N_GRAM
) (
    input  logic  clk,
    input  logic  we,
    input  addr_t idx,
    input  byte_t wdata,
    output byte_t rdata
);

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && int'(idx) < DEPTH) begin
            mem[idx] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(idx) < DEPTH) rdata = mem[idx];
    end

endmodule

// File: rtl/rtc_ext_window.sv
module rtc_ext_window
    import rtc_bank_pkg::*;
#(
    parameter int EXT_AW = 11
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  lo_we,
    input  logic  hi_we,
    input  logic  dat_we,
    input  logic  dat_re,
    input  byte_t wdata,
    output byte_t lo_q,
    output byte_t hi_q,
    output byte_t dat_q
);

    localparam int HI_W  = EXT_AW - 8;
    localparam int DEPTH = 1 << EXT_AW;

    logic [HI_W-1:0]   hi_bits;
    logic [EXT_AW-1:0] ptr;
    byte_t             mem [DEPTH];

    assign ptr  = {hi_bits, lo_q};
    assign hi_q = byte_t'(hi_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            hi_bits <= '0;
        end else begin
            if (lo_we) lo_q    <= wdata;
            if (hi_we) hi_bits <= wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (dat_we) mem[ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_q <= '0;
        end else if (dat_re) begin
            dat_q <= mem[ptr];
        end
    end

endmodule

// File: rtl/rtc_bank_regs.sv
module rtc_bank_regs
    import rtc_bank_pkg::*;
#(
    parameter int EXT_AW = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [6:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       upd_busy,
    input  logic       core_wr,
    input  logic [3:0] core_idx,
    input  logic [7:0] core_wdata,
    output logic [7:0] core_rdata,
    output logic [7:0] ctrl_a,
    output logic [7:0] ctrl_b,
    output logic [7:0] ctrl_c,
    output logic [7:0] ctrl_d,
    output logic       bank_sel
);

    decode_t                  dec;
    wstrobe_t                 wstb;
    logic                     xdat_re;
    byte_t                    time_rd, ctrl_rd, gram_rd;
    byte_t                    x_lo, x_hi, x_dat;
    logic [N_CTRL-1:0][7:0]   ctrl_q;
    byte_t                    rd_mux, rd_q;
    logic                     sel_x_q;

    assign bank_sel = ctrl_q[0][BANK_BIT];
    assign ctrl_a   = ctrl_q[0];
    assign ctrl_b   = ctrl_q[1];
    assign ctrl_c   = ctrl_q[2];
    assign ctrl_d   = ctrl_q[3];

    rtc_addr_decode i_dec (
        .addr    (bus_addr),
        .bank    (bank_sel),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .dec     (dec),
        .wstb    (wstb),
        .xdat_re (xdat_re)
    );

    rtc_core_regs i_core (
        .clk          (clk),
        .rst          (rst),
        .host_time_we (wstb.time_we),
        .host_ctrl_we (wstb.ctrl_we),
        .host_idx     (dec.idx[3:0]),
        .host_wdata   (bus_wdata),
        .upd_busy     (upd_busy),
        .core_wr      (core_wr),
        .core_idx     (core_idx),
        .core_wdata   (core_wdata),
        .host_time_rd (time_rd),
        .host_ctrl_rd (ctrl_rd),
        .ctrl_q       (ctrl_q),
        .core_rdata   (core_rdata)
    );

    rtc_gen_ram #(.DEPTH(N_GRAM)) i_gram (
        .clk   (clk),
        .we    (wstb.gram_we),
        .idx   (dec.idx),
        .wdata (bus_wdata),
        .rdata (gram_rd)
    );

    rtc_ext_window #(.EXT_AW(EXT_AW)) i_ext (
        .clk    (clk),
        .rst    (rst),
        .lo_we  (wstb.xlo_we),
        .hi_we  (wstb.xhi_we),
        .dat_we (wstb.xdat_we),
        .dat_re (xdat_re),
        .wdata  (bus_wdata),
        .lo_q   (x_lo),
        .hi_q   (x_hi),
        .dat_q  (x_dat)
    );

    always_comb begin
        unique case (dec.region)
            RG_TIME: rd_mux = time_rd;
            RG_CTRL: rd_mux = ctrl_rd;
            RG_GRAM: rd_mux = gram_rd;
            RG_XLO:  rd_mux = x_lo;
            RG_XHI:  rd_mux = x_hi;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= '0;
            sel_x_q <= 1'b0;
        end else if (bus_rd) begin
            rd_q    <= rd_mux;
            sel_x_q <= (dec.region == RG_XDAT);
        end
    end

    assign bus_rdata = sel_x_q ? x_dat : rd_q;

endmodule

// File: rtl/rtc_bank_regs_chk.sv
module rtc_bank_regs_chk #(
    parameter int EXT_AW = 11
) (
    input logic       clk,
    input logic       rst,
    input logic [6:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       upd_busy,
    input logic       core_wr,
    input logic [3:0] core_idx,
    input logic [7:0] core_wdata,
    input logic [7:0] core_rdata,
    input logic [7:0] ctrl_a,
    input logic [7:0] ctrl_b,
    input logic       bank_sel
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (bank_sel == 1'b0 && ctrl_a == 8'h00 && ctrl_b == 8'h00 && bus_rdata == 8'h00)); // R1

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R2

    AST_CTRLB_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 7'h0B) |=> (ctrl_b == $past(bus_wdata))); // R4

    AST_TIME_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (upd_busy && !core_wr) ##1 $stable(core_idx) |-> $stable(core_rdata)); // R5

    AST_XHI_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bank_sel && bus_addr == 7'h41) |=> (bus_rdata[7:EXT_AW-8] == '0)); // R8

    AST_DEAD_ZONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bank_sel && bus_addr >= 7'h43) |=> (bus_rdata == 8'h00)); // R10

    AST_CORE_WINS: assert property (@(posedge clk) disable iff (rst)
        (core_wr && core_idx < 4'd10) ##1 $stable(core_idx) |-> (core_rdata == $past(core_wdata))); // R11

endmodule

bind rtc_bank_regs rtc_bank_regs_chk #(.EXT_AW(EXT_AW)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .upd_busy   (upd_busy),
    .core_wr    (core_wr),
    .core_idx   (core_idx),
    .core_wdata (core_wdata),
    .core_rdata (core_rdata),
    .ctrl_a     (ctrl_a),
    .ctrl_b     (ctrl_b),
    .bank_sel   (bank_sel)
);

// File: tb/test_rtc_bank_regs.sv
`timescale 1ns/1ps
module test_rtc_bank_regs;

    localparam int XW = 11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       upd_busy = 1'b0;
    logic       core_wr = 1'b0;
    logic [3:0] core_idx = '0;
    logic [7:0] core_wdata = '0;
    logic [7:0] core_rdata;
    logic [7:0] ctrl_a, ctrl_b, ctrl_c, ctrl_d;
    logic       bank_sel;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    rtc_bank_regs #(.EXT_AW(XW)) i_rtc_bank_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .upd_busy(upd_busy),
        .core_wr(core_wr), .core_idx(core_idx), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .ctrl_c(ctrl_c),
        .ctrl_d(ctrl_d), .bank_sel(bank_sel)
    );

    function automatic logic [7:0] pat_g(input int a); return 8'((a * 37 + 11) & 255); endfunction
    function automatic logic [7:0] pat_t(input int a); return 8'((a * 17 + 1) & 255); endfunction
    function automatic logic [7:0] pat_x(input int i);
        return 8'((i * 29 + (i >> 8) * 71 + 5) & 255);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic core_write(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        core_idx = idx; core_wdata = d; core_wr = 1'b1;
        @(negedge clk);
        core_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 ctrl_a", ctrl_a, 8'h00);
        check("R1 ctrl_b", ctrl_b, 8'h00);
        check("R1 ctrl_c", ctrl_c, 8'h00);
        check("R1 ctrl_d", ctrl_d, 8'h00);
        check("R1 bank", {7'd0, bank_sel}, 8'h00);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); core_idx = 4'(i); #1;
            check("R1 time reg", core_rdata, 8'h00);
        end

        // R6: bank-0 general RAM sweep
        for (int a = 14; a < 128; a++) host_wr(7'(a), pat_g(a));
        for (int a = 14; a < 128; a++) begin
            host_rd(7'(a), rv);
            check("R6 gram bank0", rv, pat_g(a));
        end

        // R2: hold after read, through idle cycles and a write
        host_rd(7'h20, rv);
        repeat (3) @(negedge clk);
        check("R2 hold idle", bus_rdata, pat_g(32'h20));
        host_wr(7'h21, 8'hEE);
        check("R2 hold write", bus_rdata, pat_g(32'h20));

        // R5: time registers in bank 0, not busy
        for (int a = 0; a < 10; a++) host_wr(7'(a), pat_t(a));
        for (int a = 0; a < 10; a++) begin
            host_rd(7'(a), rv);
            check("R5 time host", rv, pat_t(a));
            @(negedge clk); core_idx = 4'(a); #1;
            check("R5 time core port", core_rdata, pat_t(a));
        end
        @(negedge clk); core_idx = 4'd12; #1;
        check("R5 core idx out of range", core_rdata, 8'h00);

        // R5: host writes ignored while busy; R4 and R6 still work while busy
        @(negedge clk); upd_busy = 1'b1;
        for (int a = 0; a < 10; a++) host_wr(7'(a), 8'hC3);
        for (int a = 0; a < 10; a++) begin
            host_rd(7'(a), rv);
            check("R5 busy write ignored", rv, pat_t(a));
        end
        host_wr(7'h0B, 8'h5A);
        check("R4 ctrl_b busy", ctrl_b, 8'h5A);
        host_wr(7'h0C, 8'hA7);
        host_rd(7'h0C, rv);
        check("R4 ctrl_c busy read", rv, 8'hA7);
        host_wr(7'h30, 8'h99);
        host_rd(7'h30, rv);
        check("R6 gram busy", rv, 8'h99);
        core_write(4'd4, 8'h77);
        check("R5 core write busy", core_rdata, 8'h77);
        host_rd(7'h04, rv);
        check("R5 host sees core write", rv, 8'h77);
        @(negedge clk); upd_busy = 1'b0;

        // R11: simultaneous core and host write to the same register
        @(negedge clk);
        bus_addr = 7'h03; bus_wdata = 8'h33; bus_wr = 1'b1;
        core_idx = 4'd3; core_wdata = 8'h5C; core_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; core_wr = 1'b0;
        check("R11 core wins port", core_rdata, 8'h5C);
        host_rd(7'h03, rv);
        check("R11 core wins host", rv, 8'h5C);

        // R3: bank select
        host_wr(7'h0A, 8'h10);
        check("R3 bank1", {7'd0, bank_sel}, 8'h01);
        check("R3 ctrl_a", ctrl_a, 8'h10);

        // R1: extended address registers start at zero
        host_rd(7'h40, rv);
        check("R1 ext lo", rv, 8'h00);
        host_rd(7'h41, rv);
        check("R1 ext hi", rv, 8'h00);

        // R4: control registers in bank 1
        host_wr(7'h0D, 8'h3C);
        check("R4 ctrl_d bank1", ctrl_d, 8'h3C);
        host_rd(7'h0B, rv);
        check("R4 ctrl_b bank1", rv, 8'h5A);

        // R5: time registers visible in bank 1
        host_rd(7'h04, rv);
        check("R5 time bank1", rv, 8'h77);

        // R7: bank-1 low RAM aliases bank-0 RAM
        for (int a = 14; a < 64; a++) begin
            host_rd(7'(a), rv);
            check("R7 alias read", rv, (a == 32'h21) ? 8'hEE : (a == 32'h30) ? 8'h99 : pat_g(a));
        end
        for (int a = 14; a < 64; a++) host_wr(7'(a), ~pat_g(a));

        // R8: extended address registers
        host_wr(7'h40, 8'hA5);
        host_rd(7'h40, rv);
        check("R8 ext lo", rv, 8'hA5);
        host_wr(7'h41, 8'hFF);
        host_rd(7'h41, rv);
        check("R8 ext hi masked", rv, 8'h07);

        // R9: full extended RAM sweep
        for (int i = 0; i < (1 << XW); i++) begin
            host_wr(7'h40, 8'(i & 255));
            host_wr(7'h41, 8'(i >> 8));
            host_wr(7'h42, pat_x(i));
        end
        for (int i = 0; i < (1 << XW); i++) begin
            host_wr(7'h40, 8'(i & 255));
            host_wr(7'h41, 8'(i >> 8));
            host_rd(7'h42, rv);
            check("R9 ext ram", rv, pat_x(i));
        end

        // R10: dead zone in bank 1
        for (int a = 67; a < 128; a++) host_wr(7'(a), 8'hB4);
        for (int a = 67; a < 128; a++) begin
            host_rd(7'(a), rv);
            check("R10 dead zone read", rv, 8'h00);
        end
        host_wr(7'h40, 8'h00);
        host_wr(7'h41, 8'h00);
        host_rd(7'h42, rv);
        check("R10 ext ram untouched", rv, pat_x(0));

        // back to bank 0: check R7 writes landed and R10 writes did not
        host_wr(7'h0A, 8'h00);
        check("R3 bank0", {7'd0, bank_sel}, 8'h00);
        for (int a = 14; a < 64; a++) begin
            host_rd(7'(a), rv);
            check("R7 alias write", rv, ~pat_g(a));
        end
        for (int a = 67; a < 128; a++) begin
            host_rd(7'(a), rv);
            check("R10 gram untouched", rv, pat_g(a));
        end
        host_rd(7'h42, rv);
        check("R6 bank0 0x42 is gram", rv, pat_g(32'h42));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule